// File: doc/BRIEF.md
# Word-to-Byte Configuration Port Streamer

This block empties a word-wide buffer RAM onto an eight-bit parallel configuration port. Word 0 of the buffer is a header that gives the number of bytes in the stream. The payload starts at word 1. Each payload word goes out as four bytes in consecutive cycles, most significant byte first. The bit order inside every byte is mirrored on the way out, so the buffer word 0xAA995566 appears on the port as the byte sequence 0x55, 0x99, 0xAA, 0x66.

A Moore state machine sequences the transfer. Its states are idle, a start cycle and four byte cycles. It runs on the falling edge of its own configuration clock, so the port lines are stable when the receiving side samples them on the rising edge. The active-low chip select and write strobe are asserted from the start cycle through the last byte. A single-cycle done pulse marks the return to idle.

The buffer is read through a plain address/word pair. The word must be valid in the same cycle its address is presented, as with an asynchronous read or a RAM clocked on the opposite edge. The port has no ready line and applies no back-pressure: once started, the machine sends one byte per clock until the stream ends. A start request that arrives while a transfer is running is ignored.

Top module: `cps_streamer`

## Requirements
- R1: After reset, port_cs_n and port_wr_n are 1, port_d is 0xFF, done is 0 and buf_addr is 0.
- R2: The header word (buffer word 0, read as an unsigned 32-bit byte count) sets the number of payload words to the byte count divided by 4, rounded up. That number is capped at 2^ADDR_W-1. Payload words are read from buffer addresses 1 upward.
- R3: A start pulse sampled in idle with a nonzero word count produces, in the next cycle, the start cycle: port_cs_n=0, port_wr_n=0 and port_d=0xFF.
- R4: After the start cycle, each payload word occupies four consecutive byte cycles. These send bits [31:24], [23:16], [15:8] and [7:0] in that order, with no gap between words and both strobes held at 0.
- R5: Each byte is mirrored on the port: port_d[i] carries bit 7-i of the selected byte (REV_BITS=1).
- R6: In the cycle after the fourth byte of the last word, the block is idle (port_cs_n=1, port_wr_n=1, port_d=0xFF) and done is 1. In the following cycle done is 0.
- R7: A start pulse with a header whose word count is 0 is ignored: the strobes stay at 1 and no done pulse occurs.
- R8: A start pulse during a transfer has no effect on the byte sequence or on the cycle in which the transfer ends.
- R9: buf_addr is 0 whenever the block is idle, so the header is always the word presented there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration clock; all state changes on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, sampled on a falling edge while idle |
| buf_addr | output | ADDR_W | Buffer word address |
| buf_word | input | 32 | Buffer word at buf_addr, valid in the same cycle |
| port_d | output | 8 | Configuration port data byte |
| port_cs_n | output | 1 | Active-low chip select |
| port_wr_n | output | 1 | Active-low write strobe |
| done | output | 1 | One-cycle pulse on return to idle |

## Verification
A start pulse sampled on one falling edge shows the start cycle on the port in the next cycle. Byte k of the transfer is due k cycles after that. The done pulse follows 4N+1 cycles after the start cycle, where N is the capped word count, and done must be low again one cycle later. The bench drives inputs and samples outputs 1 ns after each rising edge, half a period away from the falling edge where the design updates. It steps exactly one clock between samples, so every expected value lands on its computed cycle. It sweeps header byte counts from 0 to past the cap and computes the expected bytes arithmetically from the buffer pattern.

// File: rtl/cps_pkg.sv
package cps_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_B1    = 3'd2,
    ST_B2    = 3'd3,
    ST_B3    = 3'd4,
    ST_B4    = 3'd5
  } cps_state_t;

  // Lane index within the word for each byte state (0 = bits 31:24)
  function automatic logic [1:0] lane_of(cps_state_t st);
    case (st)
      ST_B2:   return 2'd1;
      ST_B3:   return 2'd2;
      ST_B4:   return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic is_byte_state(cps_state_t st);
    return (st == ST_B1) || (st == ST_B2) || (st == ST_B3) || (st == ST_B4);
  endfunction

endpackage

// File: rtl/cps_len_decode.sv
module cps_len_decode #(
  parameter int ADDR_W = 10
) (
  input  logic [31:0]       hdr,
  output logic [ADDR_W-1:0] nwords
);
  localparam logic [30:0] MAXW = 31'((64'd1 << ADDR_W) - 64'd1);

  logic [30:0] wc;

  // Round the byte count up to whole words
  assign wc     = {1'b0, hdr[31:2]} + {30'd0, |hdr[1:0]};
  assign nwords = (wc > MAXW) ? MAXW[ADDR_W-1:0] : wc[ADDR_W-1:0];
endmodule

// File: rtl/cps_word_ctr.sv
module cps_word_ctr #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [ADDR_W-1:0] nw_in,
  input  logic              inc,
  output logic              last
);
  logic [ADDR_W-1:0] cnt;
  logic [ADDR_W-1:0] nw_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      nw_q <= '0;
    end else if (clr) begin
      cnt  <= '0;
      nw_q <= nw_in;
    end else if (inc) begin
      cnt  <= cnt + 1'b1;
    end
  end

  // The word now on the port is the final one
  assign last = (({1'b0, cnt} + (ADDR_W+1)'(1)) == {1'b0, nw_q});

  // R2
  ctr_bound_chk: assert property (@(negedge clk) disable iff (!rst_n)
    (cnt <= nw_q));
endmodule

// File: rtl/cps_byte_lane.sv
module cps_byte_lane #(
  parameter bit REV_BITS = 1'b1
) (
  input  logic [31:0] word,
  input  logic [1:0]  sel,
  input  logic        en,
  output logic [7:0]  d
);
  logic [7:0] raw;
  logic [7:0] shaped;

  always_comb begin
    case (sel)
      2'd0:    raw = word[31:24];
      2'd1:    raw = word[23:16];
      2'd2:    raw = word[15:8];
      default: raw = word[7:0];
    endcase
  end

  generate
    if (REV_BITS) begin : g_rev
      for (genvar i = 0; i < 8; i++) begin : g_bit
        assign shaped[i] = raw[7-i];
      end
    end else begin : g_str
      assign shaped = raw;
    end
  endgenerate

  assign d = en ? shaped : 8'hFF;
endmodule

// File: rtl/cps_streamer.sv
module cps_streamer
  import cps_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter bit REV_BITS = 1'b1
) (
  input  logic              cfg_clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [ADDR_W-1:0] buf_addr,
  input  logic [31:0]       buf_word,
  output logic [7:0]        port_d,
  output logic              port_cs_n,
  output logic              port_wr_n,
  output logic              done
);
  localparam logic [ADDR_W-1:0] FIRST_PAYLOAD = ADDR_W'(1);

  cps_state_t        state, nxt;
  logic [ADDR_W-1:0] rd_ptr;
  logic [31:0]       cur_word;
  logic [ADDR_W-1:0] hdr_nwords;
  logic              last;
  logic              go;
  logic              load;

  cps_len_decode #(.ADDR_W(ADDR_W)) u_len (
    .hdr    (buf_word),
    .nwords (hdr_nwords)
  );

  assign go   = (state == ST_IDLE) && start && (hdr_nwords != '0);
  assign load = (state == ST_START) || ((state == ST_B4) && !last);

  cps_word_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk   (cfg_clk),
    .rst_n (rst_n),
    .clr   (go),
    .nw_in (hdr_nwords),
    .inc   (state == ST_B4),
    .last  (last)
  );

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:  nxt = go ? ST_START : ST_IDLE;
      ST_START: nxt = ST_B1;
      ST_B1:    nxt = ST_B2;
      ST_B2:    nxt = ST_B3;
      ST_B3:    nxt = ST_B4;
      ST_B4:    nxt = last ? ST_IDLE : ST_B1;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(negedge cfg_clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      rd_ptr   <= '0;
      cur_word <= '0;
      done     <= 1'b0;
    end else begin
      state <= nxt;
      done  <= (state == ST_B4) && last;
      if (go) begin
        rd_ptr <= FIRST_PAYLOAD;
      end else if (load) begin
        cur_word <= buf_word;
        rd_ptr   <= rd_ptr + 1'b1;
      end else if (nxt == ST_IDLE) begin
        rd_ptr <= '0;
      end
    end
  end

  assign buf_addr  = rd_ptr;
  assign port_cs_n = (state == ST_IDLE);
  assign port_wr_n = (state == ST_IDLE);

  cps_byte_lane #(.REV_BITS(REV_BITS)) u_lane (
    .word (cur_word),
    .sel  (lane_of(state)),
    .en   (is_byte_state(state)),
    .d    (port_d)
  );

  // R3
  start_to_b1_chk: assert property (@(negedge cfg_clk) disable iff (!rst_n)
    (state == ST_START) |=> (state == ST_B1));

  // R4
  lane_order_chk: assert property (@(negedge cfg_clk) disable iff (!rst_n)
    (state == ST_B2) |=> (state == ST_B3));

  // R6
  done_single_chk: assert property (@(negedge cfg_clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  done_idle_chk: assert property (@(negedge cfg_clk) disable iff (!rst_n)
    done |-> (port_cs_n && port_wr_n));

  // R7
  zero_len_chk: assert property (@(negedge cfg_clk) disable iff (!rst_n)
    ((state == ST_IDLE) && (hdr_nwords == '0)) |=> (state == ST_IDLE));

  // R9
  idle_addr_chk: assert property (@(negedge cfg_clk) disable iff (!rst_n)
    (done && (state == ST_IDLE)) |-> (buf_addr == '0));
endmodule

// File: tb/cps_streamer_tb.sv
module cps_streamer_tb;
  localparam int AW   = 5;
  localparam int MAXW = (1 << AW) - 1;

  logic          clk = 1'b1;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] buf_addr;
  logic [31:0]   buf_word;
  logic [7:0]    port_d;
  logic          port_cs_n, port_wr_n, done;
  logic [31:0]   mem [0:(1<<AW)-1];

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  assign buf_word = mem[buf_addr];

  cps_streamer #(.ADDR_W(AW), .REV_BITS(1'b1)) u_dut (
    .cfg_clk(clk), .rst_n(rst_n), .start(start), .buf_addr(buf_addr),
    .buf_word(buf_word), .port_d(port_d), .port_cs_n(port_cs_n),
    .port_wr_n(port_wr_n), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mirror(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  function automatic logic [31:0] pat(input int i, input logic [31:0] len);
    return (32'h9E3779B9 * (i + 1)) ^ (len * 32'h01000193);
  endfunction

  // R2 word count, computed arithmetically
  function automatic int exp_words(input logic [31:0] len);
    longint w;
    w = (longint'(len) + 3) / 4;
    return (w > MAXW) ? MAXW : int'(w);
  endfunction

  task automatic run(input logic [31:0] len, input bit poke, input bit aa_word);
    int nw;
    logic [31:0] w;
    mem[0] = len;
    for (int i = 1; i <= MAXW; i++) mem[i] = pat(i, len);
    if (aa_word) mem[1] = 32'hAA995566;
    nw = exp_words(len);
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    if (nw == 0) begin
      chk("R7 cs_n zero len", {31'd0, port_cs_n}, 32'd1);
      @(posedge clk); #1;
      chk("R7 done zero len", {31'd0, done}, 32'd0);
      chk("R7 wr_n zero len", {31'd0, port_wr_n}, 32'd1);
      return;
    end
    chk("R3 start cycle strobes", {30'd0, port_cs_n, port_wr_n}, 32'd0);
    chk("R3 start cycle data", {24'd0, port_d}, 32'hFF);
    for (int k = 0; k < 4*nw; k++) begin
      @(posedge clk); #1;
      w = mem[k/4 + 1];
      chk("R4 R5 byte", {22'd0, port_cs_n, port_wr_n, port_d},
          {24'd0, mirror(w[31 - 8*(k%4) -: 8])});
      if (poke) begin
        if (k == 2) start = 1'b1;    // R8 start during transfer
        if (k == 3) start = 1'b0;
      end
    end
    @(posedge clk); #1;
    chk("R6 done high", {31'd0, done}, 32'd1);
    chk("R6 idle strobes", {30'd0, port_cs_n, port_wr_n}, 32'd3);
    chk("R6 idle data", {24'd0, port_d}, 32'hFF);
    chk("R9 idle addr", {{(32-AW){1'b0}}, buf_addr}, 32'd0);
    @(posedge clk); #1;
    chk("R6 done low", {31'd0, done}, 32'd0);
    if (poke) chk("R8 no restart", {31'd0, port_cs_n}, 32'd1);
  endtask

  initial begin
    for (int i = 0; i <= MAXW; i++) mem[i] = 32'd0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 strobes", {30'd0, port_cs_n, port_wr_n}, 32'd3);
    chk("R1 data", {24'd0, port_d}, 32'hFF);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 addr", {{(32-AW){1'b0}}, buf_addr}, 32'd0);
    rst_n = 1'b1;
    // R5 known mirror example
    run(32'd4, 1'b0, 1'b1);
    // R2 R4 sweep over byte counts, including rounding and cap
    for (int L = 0; L <= 132; L++) run(32'(L), 1'b0, 1'b0);
    // R2 cap with a very large count
    run(32'hFFFF_FFFF, 1'b0, 1'b0);
    // R8 start while busy
    run(32'd20, 1'b1, 1'b0);
    run(32'd5, 1'b1, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule